// File: doc/BRIEF.md
# Four-Entry Segment Mapping File

This block extends a 15-bit CPU window address to a 19-bit physical memory address. The window is split into four 8 KB segments. Each segment is redirected to one of sixteen 32 KB physical banks through a small 4-entry by 4-bit mapping file. The two top window-address bits pick the entry, and that entry's contents become the top four physical address bits. The low fifteen bits pass straight through. Translation is combinational, so the physical address follows the CPU address in the same cycle.

Software programs the file through one register address. The address decoder asserts `map_wr` for one clock when it sees a write to that address, and the write is already qualified by the bus phase. On that write, one data field gives the entry number and another gives the bank number. A single location can therefore reprogram any of the four segments. While `map_wr` is high, the entry index comes from the data field instead of the address. The file has no reset, so software must program all four entries before it relies on translation.

A read-back path returns the entry named by the most recent mapper write. Software can use it to confirm a mapping. Because the mapper port carries plain control and status pins with no streaming data, it has no valid/ready handshake.

Top module: `seg_map_file`

## Requirements
- R1: `phys_addr[14:0]` always equals `cpu_addr[14:0]`.
- R2: While `map_wr` is low, `phys_addr[18:15]` equals the entry selected by `cpu_addr[14:13]`, combinationally in the same cycle.
- R3: A rising clock edge with `map_wr` high stores `cpu_data[3:0]` into the entry numbered by `cpu_data[5:4]`. The new value is visible from the next cycle.
- R4: A mapper write leaves the other three entries unchanged. A cycle without `map_wr` changes no entry.
- R5: While `map_wr` is high, `phys_addr[18:15]` shows the pre-write contents of the entry numbered by `cpu_data[5:4]`, whatever `cpu_addr[14:13]` holds.
- R6: `cpu_data[7:6]` has no effect on the stored value or on the entry chosen.
- R7: `rb_data` returns the entry numbered by `cpu_data[5:4]` of the most recent mapper write. After reset, that index is 0.
- R8: `rst_n` does not clear or alter the mapping entries.
- R9: Writes to the same entry in back-to-back cycles leave the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears only the read-back index |
| cpu_addr | input | 15 | CPU window address; bits 14:13 pick the segment |
| cpu_data | input | 8 | CPU write data; bits 5:4 entry number, bits 3:0 bank |
| map_wr | input | 1 | One-cycle, phase-qualified write to the mapper register |
| phys_addr | output | 19 | Physical address: bank in bits 18:15, offset below |
| rb_data | output | 4 | Entry named by the last mapper write |

## Verification
The assertions check, on every cycle, that:
- a write lands in exactly the addressed entry (R3);
- every other entry holds its value through a write or an idle cycle (R4, R9);
- the read-back index follows the data field of each write (R7).

Only the bench scenarios can show the rest:
- that the index source switches from address to data while a write is pending (R5);
- that the top data bits are ignored (R6);
- that the mapping survives a reset pulse (R8);
- that the composed physical address is right for each segment across a range of offsets (R1, R2).

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;
  localparam int DEF_SEG_BITS    = 2;
  localparam int DEF_BANK_BITS   = 4;
  localparam int DEF_OFFSET_BITS = 13;
  localparam int DEF_DATA_W      = 8;

  typedef enum logic {
    IDX_FROM_ADDR = 1'b0,
    IDX_FROM_DATA = 1'b1
  } idx_src_e;
endpackage

// File: rtl/seg_map_index_mux.sv
module seg_map_index_mux
  import seg_map_pkg::*;
#(
  parameter int SEG_BITS    = DEF_SEG_BITS,
  parameter int BANK_BITS   = DEF_BANK_BITS,
  parameter int OFFSET_BITS = DEF_OFFSET_BITS,
  parameter int DATA_W      = DEF_DATA_W,
  localparam int WIN_BITS   = OFFSET_BITS + SEG_BITS
) (
  input  logic [WIN_BITS-1:0] win_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_req,
  output logic [SEG_BITS-1:0] sel_idx,
  output logic [SEG_BITS-1:0] data_idx,
  output logic [BANK_BITS-1:0] data_bank,
  output idx_src_e            sel_src
);
  // The data word is split into bank (low) and entry number (above it);
  // anything above that is dropped.
  assign data_bank = wr_data[BANK_BITS-1:0];
  assign data_idx  = wr_data[BANK_BITS +: SEG_BITS];

  always_comb begin
    sel_src = wr_req ? IDX_FROM_DATA : IDX_FROM_ADDR;
    unique case (sel_src)
      IDX_FROM_DATA: sel_idx = data_idx;
      default:       sel_idx = win_addr[OFFSET_BITS +: SEG_BITS];
    endcase
  end
endmodule

// File: rtl/seg_map_regfile.sv
module seg_map_regfile
  import seg_map_pkg::*;
#(
  parameter int SEG_BITS  = DEF_SEG_BITS,
  parameter int BANK_BITS = DEF_BANK_BITS,
  localparam int ENTRIES  = 1 << SEG_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEG_BITS-1:0]  wr_idx,
  input  logic [BANK_BITS-1:0] wr_bank,
  input  logic [SEG_BITS-1:0]  xlat_idx,
  output logic [BANK_BITS-1:0] xlat_bank,
  input  logic [SEG_BITS-1:0]  peek_idx,
  output logic [BANK_BITS-1:0] peek_bank
);
  // No reset on the storage: contents are whatever power-up leaves.
  logic [BANK_BITS-1:0] slot [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == SEG_BITS'(k));

    always_ff @(posedge clk) begin
      if (hit) slot[k] <= wr_bank;
    end

    AST_OTHER_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == SEG_BITS'(k)) |=> $stable(slot[k])); // R4
  end

  assign xlat_bank = slot[xlat_idx];
  assign peek_bank = slot[peek_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot[$past(wr_idx)] == $past(wr_bank)); // R3
endmodule

// File: rtl/seg_map_readback.sv
module seg_map_readback
  import seg_map_pkg::*;
#(
  parameter int SEG_BITS  = DEF_SEG_BITS,
  parameter int BANK_BITS = DEF_BANK_BITS,
  parameter bit HAS_RB    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEG_BITS-1:0]  wr_idx,
  output logic [SEG_BITS-1:0]  peek_idx,
  input  logic [BANK_BITS-1:0] peek_bank,
  output logic [BANK_BITS-1:0] rb_out
);
  if (HAS_RB) begin : g_rb
    logic [SEG_BITS-1:0] last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     last_idx <= '0;
      else if (wr_en) last_idx <= wr_idx;
    end

    assign peek_idx = last_idx;
    assign rb_out   = peek_bank;

    AST_RB_INDEX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> last_idx == $past(wr_idx)); // R7
    AST_RB_INDEX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(last_idx)); // R7
  end else begin : g_no_rb
    assign peek_idx = '0;
    assign rb_out   = '0;
  end
endmodule

// File: rtl/seg_map_file.sv
module seg_map_file
  import seg_map_pkg::*;
#(
  parameter int SEG_BITS    = DEF_SEG_BITS,
  parameter int BANK_BITS   = DEF_BANK_BITS,
  parameter int OFFSET_BITS = DEF_OFFSET_BITS,
  parameter int DATA_W      = DEF_DATA_W,
  parameter bit HAS_RB      = 1'b1,
  localparam int WIN_BITS   = OFFSET_BITS + SEG_BITS,
  localparam int BANK_SPAN  = WIN_BITS,
  localparam int PHYS_BITS  = BANK_SPAN + BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WIN_BITS-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]    cpu_data,
  input  logic                 map_wr,
  output logic [PHYS_BITS-1:0] phys_addr,
  output logic [BANK_BITS-1:0] rb_data
);
  logic [SEG_BITS-1:0]  sel_idx, data_idx, peek_idx;
  logic [BANK_BITS-1:0] data_bank, xlat_bank, peek_bank;
  idx_src_e             sel_src;

  seg_map_index_mux #(
    .SEG_BITS(SEG_BITS), .BANK_BITS(BANK_BITS),
    .OFFSET_BITS(OFFSET_BITS), .DATA_W(DATA_W)
  ) u_mux (
    .win_addr(cpu_addr), .wr_data(cpu_data), .wr_req(map_wr),
    .sel_idx(sel_idx), .data_idx(data_idx), .data_bank(data_bank),
    .sel_src(sel_src)
  );

  seg_map_regfile #(.SEG_BITS(SEG_BITS), .BANK_BITS(BANK_BITS)) u_file (
    .clk(clk), .rst_n(rst_n),
    .wr_en(map_wr), .wr_idx(data_idx), .wr_bank(data_bank),
    .xlat_idx(sel_idx), .xlat_bank(xlat_bank),
    .peek_idx(peek_idx), .peek_bank(peek_bank)
  );

  seg_map_readback #(
    .SEG_BITS(SEG_BITS), .BANK_BITS(BANK_BITS), .HAS_RB(HAS_RB)
  ) u_rb (
    .clk(clk), .rst_n(rst_n), .wr_en(map_wr), .wr_idx(data_idx),
    .peek_idx(peek_idx), .peek_bank(peek_bank), .rb_out(rb_data)
  );

  assign phys_addr = {xlat_bank, cpu_addr};

  AST_SRC_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |-> sel_src == IDX_FROM_DATA); // R5
endmodule

// File: tb/seg_map_file_bench.sv
module seg_map_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        map_wr = 1'b0;
  logic [18:0] phys_addr;
  logic [3:0]  rb_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_map [4];
  logic [1:0] exp_rb;

  always #10 clk = ~clk;

  seg_map_file u_seg_map_file (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .map_wr(map_wr), .phys_addr(phys_addr), .rb_data(rb_data)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, hold across one rising edge.
  task automatic wr(input logic [1:0] idx, input logic [3:0] bank, input logic [1:0] junk);
    @(negedge clk);
    cpu_data = {junk, idx, bank};
    map_wr = 1'b1;
    @(negedge clk);
    map_wr = 1'b0;
    exp_map[idx] = bank;
    exp_rb = idx;
  endtask

  task automatic look(input logic [14:0] a, input string tag);
    @(negedge clk);
    cpu_addr = a;
    #3;
    chk(phys_addr, {exp_map[a[14:13]], a}, tag);
  endtask

  task automatic t_program_all;
    for (int k = 0; k < 4; k++) begin
      wr(2'(k), 4'(4'hA + k), 2'b00);
      #3 chk(rb_data, exp_map[k], "R7 readback after write");
    end
  endtask

  task automatic t_translate;
    for (int s = 0; s < 4; s++) begin
      look({2'(s), 13'h0000}, "R2 segment base");
      look({2'(s), 13'h1FFF}, "R1 segment top offset");
      look({2'(s), 13'h0A5C}, "R1 mid offset");
    end
  endtask

  task automatic t_write_path;
    logic [3:0] old2;
    old2 = exp_map[2];
    @(negedge clk);
    cpu_addr = 15'h0123;
    cpu_data = {2'b00, 2'd2, 4'h3};
    map_wr = 1'b1;
    #3 chk(phys_addr[18:15], old2, "R5 index from data during write");
    chk(phys_addr[14:0], 15'h0123, "R1 offset during write");
    @(negedge clk);
    map_wr = 1'b0;
    exp_map[2] = 4'h3;
    exp_rb = 2'd2;
    for (int s = 0; s < 4; s++) look({2'(s), 13'h0040}, "R3/R4 after single write");
  endtask

  task automatic t_high_bits;
    wr(2'd1, 4'h7, 2'b11);
    #3 chk(rb_data, 4'h7, "R6 top bits ignored readback");
    look({2'd1, 13'h0002}, "R6 top bits ignored translate");
    look({2'd3, 13'h0002}, "R6 no stray entry");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    cpu_data = {2'b00, 2'd0, 4'h5};
    map_wr = 1'b1;
    @(negedge clk);
    cpu_data = {2'b00, 2'd0, 4'hE};
    @(negedge clk);
    map_wr = 1'b0;
    exp_map[0] = 4'hE;
    exp_rb = 2'd0;
    #3 chk(rb_data, 4'hE, "R9 last write wins");
    look({2'd0, 13'h1234}, "R9 translate after repeat");
  endtask

  task automatic t_reset_keep;
    wr(2'd3, 4'h9, 2'b00);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #3 chk(rb_data, exp_map[0], "R7 readback index 0 after reset");
    for (int s = 0; s < 4; s++) look({2'(s), 13'h0777}, "R8 entries kept over reset");
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_program_all();
    t_translate();
    t_write_path();
    t_high_bits();
    t_back_to_back();
    t_reset_keep();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule